// File: doc/BRIEF.md
# Exponential Backoff Retry Sequencer

This block paces the retries of a requester whose compare-and-swap attempts keep losing to competing threads. It holds a backoff multiplier that is set to one at the start of every new atomic operation. Each failed attempt makes the block wait for a time equal to the multiplier times 128 cycles, and then doubles the multiplier for the next failure. Once the multiplier has passed the limit of 4096 it stops growing.

Two wait mechanisms are available, selected per failure by a mode input. In request mode the block asks an external pause unit for the whole wait as one request, holds that request with its cycle count, and waits for a done indication. In stall-loop mode the block counts the wait itself, in units of 128 cycles. In both cases the wait ends with a one-cycle retry-go pulse, after which a new attempt outcome is accepted. A success returns the block to idle.

Top module: `backoff_seq`

## Requirements
- R1: After reset, pause_req_o and retry_go_o are low, and the first failure after a start asks for 128 cycles.
- R2: Each failure in request mode raises pause_req_o in the next cycle, with pause_cycles_o equal to the multiplier times 128. That count stays constant while the request is high.
- R3: The multiplier doubles after each failure while it is at most 4096. The comparison is strictly greater-than, so 4096 still doubles to 8192, and the multiplier stays at 8192 from then on. Successive pauses are therefore 128, 256, …, 1048576, 1048576.
- R4: start_i in idle sets the multiplier to one and begins an operation. start_i is ignored while an operation is in progress.
- R5: In request mode, pause_req_o stays high until pause_done_i is seen. retry_go_o is then high for exactly one cycle, starting the cycle after pause_done_i.
- R6: When legacy_i is high in the cycle of a failure, no pause request is made. retry_go_o rises after exactly multiplier times 128 stall cycles, and pause_done_i has no effect during that wait.
- R7: A success returns the block to idle and resets the multiplier. When success_i and fail_i arrive together, success wins and no pause follows.
- R8: fail_i outside an attempt has no effect, and pause_done_i outside a request-mode pause has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new atomic operation |
| fail_i | input | 1 | Current attempt failed |
| success_i | input | 1 | Current attempt succeeded |
| pause_done_i | input | 1 | External pause has completed |
| legacy_i | input | 1 | Use the internal stall loop for this failure |
| pause_req_o | output | 1 | Pause request, held until done |
| pause_cycles_o | output | 21 | Requested pause length in cycles |
| retry_go_o | output | 1 | One-cycle permission to retry |

## Verification
Two attempt outcomes can arrive in the same cycle: success_i and fail_i. The bench drives both high together while an attempt is open. It then checks that no pause request follows and that the next failure is ignored, because the block is back in idle. A stray pause_done_i in the middle of a stall-loop wait is also raised, to show that it does not cut the counted wait short. A behavioural model is compared with the outputs on every clock.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ATTEMPT,
    ST_PAUSE,
    ST_RETRY
  } bo_state_e;
endpackage

// File: rtl/backoff_mult.sv
module backoff_mult #(
  parameter int MULT_W = 14,
  parameter int LIMIT  = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  output logic [MULT_W-1:0] mult_o
);
  localparam logic [MULT_W-1:0] LIM = MULT_W'(LIMIT);

  logic [MULT_W-1:0] mult_q;

  // Cap test happens before doubling: value settles one step above LIMIT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       mult_q <= MULT_W'(1);
    else if (init_i)                   mult_q <= MULT_W'(1);
    else if (step_i && !(mult_q > LIM)) mult_q <= mult_q << 1;
  end

  assign mult_o = mult_q;
endmodule

// File: rtl/backoff_stall.sv
module backoff_stall #(
  parameter int CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] amount_i,
  input  logic             legacy_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] amount_o,
  output logic             legacy_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] amt_q, cnt_q;
  logic             leg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amt_q <= '0;
      cnt_q <= '0;
      leg_q <= 1'b0;
    end else if (load_i) begin
      amt_q <= amount_i;
      cnt_q <= amount_i - CNT_W'(1);
      leg_q <= legacy_i;
    end else if (run_i && leg_q && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign amount_o  = amt_q;
  assign legacy_o  = leg_q;
  assign expired_o = leg_q && (cnt_q == '0);
endmodule

// File: rtl/backoff_seq.sv
module backoff_seq #(
  parameter int MULT_W     = 14,
  parameter int LIMIT      = 4096,
  parameter int UNIT_SHIFT = 7,
  localparam int CNT_W     = MULT_W + UNIT_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fail_i,
  input  logic             success_i,
  input  logic             pause_done_i,
  input  logic             legacy_i,
  output logic             pause_req_o,
  output logic [CNT_W-1:0] pause_cycles_o,
  output logic             retry_go_o
);
  import backoff_pkg::*;

  bo_state_e         st_q, st_d;
  logic [MULT_W-1:0] mult_q;
  logic              take_fail, init_mult;
  logic [CNT_W-1:0]  amount, amt_q;
  logic              leg_q, expired;

  assign take_fail = (st_q == ST_ATTEMPT) && fail_i && !success_i;
  assign init_mult = ((st_q == ST_IDLE) && start_i) ||
                     ((st_q == ST_ATTEMPT) && success_i);
  assign amount    = CNT_W'(mult_q) << UNIT_SHIFT;

  backoff_mult #(.MULT_W(MULT_W), .LIMIT(LIMIT)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_mult),
    .step_i (take_fail),
    .mult_o (mult_q)
  );

  backoff_stall #(.CNT_W(CNT_W)) u_stall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (take_fail),
    .amount_i  (amount),
    .legacy_i  (legacy_i),
    .run_i     (st_q == ST_PAUSE),
    .amount_o  (amt_q),
    .legacy_o  (leg_q),
    .expired_o (expired)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_ATTEMPT;
      ST_ATTEMPT: begin
        if (success_i)   st_d = ST_IDLE;
        else if (fail_i) st_d = ST_PAUSE;
      end
      ST_PAUSE:   if (leg_q ? expired : pause_done_i) st_d = ST_RETRY;
      ST_RETRY:   st_d = ST_ATTEMPT;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign pause_req_o    = (st_q == ST_PAUSE) && !leg_q;
  assign pause_cycles_o = amt_q;
  assign retry_go_o     = (st_q == ST_RETRY);
endmodule

// File: rtl/backoff_seq_chk.sv
module backoff_seq_chk #(
  parameter int MULT_W     = 14,
  parameter int LIMIT      = 4096,
  parameter int UNIT_SHIFT = 7,
  localparam int CNT_W     = MULT_W + UNIT_SHIFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pause_done_i,
  input logic              pause_req_o,
  input logic [CNT_W-1:0]  pause_cycles_o,
  input logic              retry_go_o,
  input logic [MULT_W-1:0] mult_q,
  input logic              step
);
  a_r2_amount: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_req_o) |-> pause_cycles_o == (CNT_W'($past(mult_q)) << UNIT_SHIFT));

  a_r2_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o && $past(pause_req_o) |-> $stable(pause_cycles_o));

  a_r3_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && (mult_q <= MULT_W'(LIMIT)) |=> mult_q == ($past(mult_q) << 1));

  a_r3_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_q <= MULT_W'(2 * LIMIT));

  a_r5_done_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o && pause_done_i |=> retry_go_o);

  a_r5_go_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_go_o |=> !retry_go_o);
endmodule

bind backoff_seq backoff_seq_chk #(
  .MULT_W(MULT_W), .LIMIT(LIMIT), .UNIT_SHIFT(UNIT_SHIFT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pause_done_i   (pause_done_i),
  .pause_req_o    (pause_req_o),
  .pause_cycles_o (pause_cycles_o),
  .retry_go_o     (retry_go_o),
  .mult_q         (mult_q),
  .step           (take_fail)
);

// File: tb/backoff_seq_test.sv
module backoff_seq_test;
  localparam int CNT_W = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, fail = 0, success = 0, pdone = 0, legacy = 0;
  logic             req, go;
  logic [CNT_W-1:0] cycles;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  backoff_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fail_i(fail),
    .success_i(success), .pause_done_i(pdone), .legacy_i(legacy),
    .pause_req_o(req), .pause_cycles_o(cycles), .retry_go_o(go)
  );

  // Behavioural reference: 0 idle, 1 attempt, 2 pause, 3 retry
  int m_st, m_mult, m_amt, m_cnt;
  bit m_leg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mult = 1; m_amt = 0; m_cnt = 0; m_leg = 0;
    end else begin
      case (m_st)
        0: if (start) begin m_st = 1; m_mult = 1; end
        1: if (success) begin m_st = 0; m_mult = 1; end
           else if (fail) begin
             m_st = 2; m_amt = m_mult * 128; m_cnt = m_amt; m_leg = legacy;
             if (m_mult <= 4096) m_mult = m_mult * 2;
           end
        2: if (m_leg) begin
             m_cnt = m_cnt - 1;
             if (m_cnt == 0) m_st = 3;
           end else if (pdone) m_st = 3;
        default: m_st = 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(req == (m_st == 2 && !m_leg), "R5 model pause_req_o", int'(req), int'(m_st == 2 && !m_leg));
    chk(go == (m_st == 3), "R5 model retry_go_o", int'(go), int'(m_st == 3));
    if (req) chk(int'(cycles) == m_amt, "R2 model pause_cycles_o", int'(cycles), m_amt);
  endtask

  task automatic do_start();
    start = 1; step(); start = 0;
  endtask

  task automatic fail_once(input int exp, input string tag);
    fail = 1; step(); fail = 0;
    chk(req == 1'b1, tag, int'(req), 1);
    chk(int'(cycles) == exp, tag, int'(cycles), exp);
    step();
    chk(req == 1'b1 && go == 1'b0, "R5 held until done", int'(req), 1);
    pdone = 1; step(); pdone = 0;
    chk(go == 1'b1 && req == 1'b0, "R5 go after done", int'(go), 1);
    step();
    chk(go == 1'b0, "R5 go single cycle", int'(go), 0);
  endtask

  task automatic legacy_once(input int exp);
    int n;
    legacy = 1; fail = 1; step(); fail = 0; legacy = 0;
    chk(req == 1'b0, "R6 no request in stall mode", int'(req), 0);
    n = 0;
    while (!go && n < 20000) begin
      if (n == 10) pdone = 1;
      step();
      pdone = 0;
      chk(req == 1'b0, "R6 no request while stalling", int'(req), 0);
      n++;
    end
    chk(n == exp, "R6 stall length", n, exp);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R1 reset pause_req_o", int'(req), 0);
    chk(go == 1'b0, "R1 reset retry_go_o", int'(go), 0);
    rst_n = 1;
    step();

    // R1, R3: growth through the cap
    do_start();
    for (int i = 0; i < 16; i++) begin
      int e;
      e = (1 << ((i < 13) ? i : 13)) * 128;
      fail_once(e, (i == 0) ? "R1 first pause" : "R3 pause length");
    end

    // R7: success resets; R8: fail in idle ignored
    success = 1; step(); success = 0;
    fail = 1; step(); fail = 0;
    chk(req == 1'b0, "R8 fail in idle ignored", int'(req), 0);
    step();
    chk(req == 1'b0, "R8 still no request", int'(req), 0);

    // R4: start resets; start mid-operation ignored
    do_start();
    fail_once(128, "R4 restart at one");
    fail_once(256, "R3 second pause");
    do_start();
    fail_once(512, "R4 start ignored mid-operation");

    // R7: simultaneous success and fail
    success = 1; fail = 1; step(); success = 0; fail = 0;
    chk(req == 1'b0, "R7 success wins", int'(req), 0);
    fail = 1; step(); fail = 0;
    chk(req == 1'b0, "R7 block returned to idle", int'(req), 0);

    // R8: pause_done outside a pause
    do_start();
    pdone = 1; step(); pdone = 0;
    chk(go == 1'b0, "R8 stray done no go", int'(go), 0);
    step();
    chk(go == 1'b0 && req == 1'b0, "R8 stray done no effect", int'(go), 0);
    fail_once(128, "R8 multiplier untouched");

    // R6: stall-loop mode
    success = 1; step(); success = 0;
    do_start();
    legacy_once(128);
    legacy_once(256);
    fail_once(512, "R6 multiplier shared across modes");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule